// File: doc/BRIEF.md
# Energy-Aware Loss Threshold Guard

This block watches a stream of freshly updated loss integrals, one integral per cycle, each tagged with the detector channel and the integration window it belongs to. It checks every integral against a limit. The limit comes from a table indexed by the beam energy level at that moment, the channel and the window. An integral strictly above its limit raises an abort request for its channel.

A class filter then sorts the requests. A channel wired as unconnected is ignored. A connected maskable channel can be silenced by an operator inhibit. A connected unmaskable channel always gets through. Any request that survives is latched, and the beam permit drops. The permit stays low until a clear strobe arrives.

Alongside the protection path, the block tracks the largest integral seen in each channel and window slot during the current second. It also keeps the limit that applied when that largest value arrived. On each second tick, these running maxima are frozen into a record bank that can be read at any time, and the running maxima restart from zero.

Top module: `loss_threshold_guard`

## Requirements
- R1: The limit for an integral is read from table address {energy[4:0], channel, window[3:0]} using the energy level present on the cycle the integral arrives; changing the energy selects a different limit.
- R2: An integral strictly greater than its limit is a violation; an integral equal to its limit is not.
- R3: An integral accepted at clock edge k can clear `beam_permit` only after edge k+1, never earlier.
- R4: An integral on a channel whose `ch_connected` bit is 0 never affects `beam_permit` or `trip_ch`.
- R5: When `inhibit` is 1, violations on connected channels whose `ch_maskable` bit is 1 are dropped; when `inhibit` is 0, they trip.
- R6: A violation on a connected channel whose `ch_maskable` bit is 0 always trips, whatever the state of `inhibit`.
- R7: Once tripped, `beam_permit` stays 0 until `permit_clear` is pulsed. A clear that comes with no new violation returns `beam_permit` to 1 after the next edge.
- R8: After reset, `beam_permit` is 1, `trip_ch` is 0, and every record reads 0.
- R9: On `second_tick`, each slot's record takes the largest integral seen since the previous tick, together with its limit (the later limit wins on a tie). The running maximum then restarts from 0. Slot (ch, w) is read through `rd_ch`/`rd_win`.
- R10: Bit c of `trip_ch` is 1 exactly for the channels whose violations have been latched since the last clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_we | input | 1 | Limit table write enable |
| thr_addr | input | E_W+CH_W+WIN_W | Limit table write address {energy, channel, window} |
| thr_wdata | input | THR_W | Limit value to write |
| sum_valid | input | 1 | Integral present this cycle |
| sum_ch | input | CH_W | Channel of the integral |
| sum_win | input | WIN_W | Window index of the integral |
| sum_val | input | SUM_W | Unsigned integral value |
| energy | input | E_W | Quantized beam energy level |
| ch_connected | input | 2**CH_W | Per-channel connected flag |
| ch_maskable | input | 2**CH_W | Per-channel maskable flag |
| inhibit | input | 1 | Operator inhibit for maskable channels |
| permit_clear | input | 1 | Strobe that clears latched trips |
| second_tick | input | 1 | One-second strobe that freezes the maxima |
| rd_ch | input | CH_W | Record read channel |
| rd_win | input | WIN_W | Record read window |
| beam_permit | output | 1 | 1 while no trip is latched |
| trip_ch | output | 2**CH_W | Latched per-channel trip flags |
| rd_max | output | SUM_W | Recorded maximum for the selected slot |
| rd_thr | output | THR_W | Limit that applied to that maximum |

## Verification
The in-module assertions check the class rules on every cycle. An unmaskable violation must drop the permit on the next edge. An unconnected or inhibited maskable integral must leave a high permit high. An integral equal to its limit must not trip, and a dropped permit must stay down until a clear. The bench's scenarios are needed for the rest: the full address mapping of the limit table, the one-cycle latency, the per-channel trip flags, and the per-second records. For those, the bench sweeps every energy, channel and window combination and compares against limits it computes itself.

// File: rtl/loss_threshold_guard.sv
module loss_threshold_guard #(
  parameter int CH_W  = 2,
  parameter int WIN_W = 4,
  parameter int N_WIN = 12,
  parameter int E_W   = 5,
  parameter int SUM_W = 24,
  parameter int THR_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       thr_we,
  input  logic [E_W+CH_W+WIN_W-1:0]  thr_addr,
  input  logic [THR_W-1:0]           thr_wdata,
  input  logic                       sum_valid,
  input  logic [CH_W-1:0]            sum_ch,
  input  logic [WIN_W-1:0]           sum_win,
  input  logic [SUM_W-1:0]           sum_val,
  input  logic [E_W-1:0]             energy,
  input  logic [(1<<CH_W)-1:0]       ch_connected,
  input  logic [(1<<CH_W)-1:0]       ch_maskable,
  input  logic                       inhibit,
  input  logic                       permit_clear,
  input  logic                       second_tick,
  input  logic [CH_W-1:0]            rd_ch,
  input  logic [WIN_W-1:0]           rd_win,
  output logic                       beam_permit,
  output logic [(1<<CH_W)-1:0]       trip_ch,
  output logic [SUM_W-1:0]           rd_max,
  output logic [THR_W-1:0]           rd_thr
);
  localparam int N_CH   = 1 << CH_W;
  localparam int AW     = E_W + CH_W + WIN_W;
  localparam int N_SLOT = N_CH * N_WIN;
  localparam int SW     = $clog2(N_SLOT + (1 << WIN_W));

  logic [THR_W-1:0] thr_mem [0:(1<<AW)-1];
  logic [THR_W-1:0] thr_q;

  always_ff @(posedge clk) begin
    if (thr_we) thr_mem[thr_addr] <= thr_wdata;
    thr_q <= thr_mem[{energy, sum_ch, sum_win}];
  end

  logic             p_valid;
  logic [CH_W-1:0]  p_ch;
  logic [WIN_W-1:0] p_win;
  logic [SUM_W-1:0] p_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_valid <= 1'b0;
      p_ch    <= '0;
      p_win   <= '0;
      p_val   <= '0;
    end else begin
      p_valid <= sum_valid;
      p_ch    <= sum_ch;
      p_win   <= sum_win;
      p_val   <= sum_val;
    end
  end

  wire [SUM_W-1:0] thr_ext = SUM_W'(thr_q);
  wire             over    = p_valid && (p_val > thr_ext);

  logic [N_CH-1:0] req;
  logic [N_CH-1:0] trip_q;

  for (genvar c = 0; c < N_CH; c++) begin : g_req
    assign req[c] = over && (p_ch == CH_W'(c)) && ch_connected[c]
                    && !(ch_maskable[c] && inhibit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            trip_q <= '0;
    else if (permit_clear) trip_q <= req;
    else                   trip_q <= trip_q | req;
  end

  assign beam_permit = ~|trip_q;
  assign trip_ch     = trip_q;

  wire [SW-1:0] p_slot  = SW'(p_ch) * SW'(N_WIN) + SW'(p_win);
  wire [SW-1:0] rd_slot = SW'(rd_ch) * SW'(N_WIN) + SW'(rd_win);

  logic [SUM_W-1:0] run_max [N_SLOT];
  logic [THR_W-1:0] run_thr [N_SLOT];
  logic [SUM_W-1:0] rec_max [N_SLOT];
  logic [THR_W-1:0] rec_thr [N_SLOT];

  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    wire              hit   = p_valid && (p_win < WIN_W'(N_WIN))
                              && (p_slot == SW'(s)) && (p_val >= run_max[s]);
    wire [SUM_W-1:0]  nxt_m = hit ? p_val : run_max[s];
    wire [THR_W-1:0]  nxt_t = hit ? thr_q : run_thr[s];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        run_max[s] <= '0;
        run_thr[s] <= '0;
        rec_max[s] <= '0;
        rec_thr[s] <= '0;
      end else if (second_tick) begin
        rec_max[s] <= nxt_m;
        rec_thr[s] <= nxt_t;
        run_max[s] <= '0;
        run_thr[s] <= '0;
      end else begin
        run_max[s] <= nxt_m;
        run_thr[s] <= nxt_t;
      end
    end
  end

  wire rd_ok = (rd_win < WIN_W'(N_WIN));
  assign rd_max = rd_ok ? rec_max[rd_slot[$clog2(N_SLOT)-1:0]] : '0;
  assign rd_thr = rd_ok ? rec_thr[rd_slot[$clog2(N_SLOT)-1:0]] : '0;

  a_r6_unmaskable_trips: assert property (@(posedge clk) disable iff (!rst_n)
    (over && ch_connected[p_ch] && !ch_maskable[p_ch]) |=> !beam_permit);

  a_r4_unconnected_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (p_valid && !ch_connected[p_ch] && beam_permit && !permit_clear) |=> beam_permit);

  a_r5_inhibit_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (p_valid && ch_connected[p_ch] && ch_maskable[p_ch] && inhibit
     && beam_permit && !permit_clear) |=> beam_permit);

  a_r2_equal_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (p_valid && (p_val == thr_ext) && beam_permit && !permit_clear) |=> beam_permit);

  a_r7_trip_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (!beam_permit && !permit_clear) |=> !beam_permit);
endmodule

// File: tb/loss_threshold_guard_tb.sv
module loss_threshold_guard_tb;
  localparam int CH_W = 2, WIN_W = 4, N_WIN = 12, E_W = 5, SUM_W = 24, THR_W = 16;
  localparam int N_CH = 1 << CH_W;
  localparam int AW = E_W + CH_W + WIN_W;

  logic clk = 0, rst_n = 0;
  logic thr_we = 0;
  logic [AW-1:0] thr_addr = '0;
  logic [THR_W-1:0] thr_wdata = '0;
  logic sum_valid = 0;
  logic [CH_W-1:0] sum_ch = '0;
  logic [WIN_W-1:0] sum_win = '0;
  logic [SUM_W-1:0] sum_val = '0;
  logic [E_W-1:0] energy = '0;
  logic [N_CH-1:0] ch_connected = 4'b1011;
  logic [N_CH-1:0] ch_maskable  = 4'b1010;
  logic inhibit = 0, permit_clear = 0, second_tick = 0;
  logic [CH_W-1:0] rd_ch = '0;
  logic [WIN_W-1:0] rd_win = '0;
  logic beam_permit;
  logic [N_CH-1:0] trip_ch;
  logic [SUM_W-1:0] rd_max;
  logic [THR_W-1:0] rd_thr;

  int errors = 0, checks = 0;
  logic early_permit;

  loss_threshold_guard #(.CH_W(CH_W), .WIN_W(WIN_W), .N_WIN(N_WIN), .E_W(E_W),
    .SUM_W(SUM_W), .THR_W(THR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .thr_we(thr_we), .thr_addr(thr_addr),
    .thr_wdata(thr_wdata), .sum_valid(sum_valid), .sum_ch(sum_ch),
    .sum_win(sum_win), .sum_val(sum_val), .energy(energy),
    .ch_connected(ch_connected), .ch_maskable(ch_maskable), .inhibit(inhibit),
    .permit_clear(permit_clear), .second_tick(second_tick), .rd_ch(rd_ch),
    .rd_win(rd_win), .beam_permit(beam_permit), .trip_ch(trip_ch),
    .rd_max(rd_max), .rd_thr(rd_thr));

  always #4 clk = ~clk;

  function automatic int thr_of(int e, int c, int w);
    return 100 + 8 * e + 3 * c + w;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(int c, int w, int e, int v);
    @(negedge clk);
    sum_valid = 1; sum_ch = CH_W'(c); sum_win = WIN_W'(w);
    energy = E_W'(e); sum_val = SUM_W'(v);
    @(negedge clk);
    sum_valid = 0;
    early_permit = beam_permit;
    @(negedge clk);
  endtask

  task automatic pulse_clear();
    @(negedge clk); permit_clear = 1;
    @(negedge clk); permit_clear = 0;
  endtask

  task automatic tick();
    @(negedge clk); second_tick = 1;
    @(negedge clk); second_tick = 0;
  endtask

  task automatic rd(int c, int w);
    rd_ch = CH_W'(c); rd_win = WIN_W'(w);
    #1;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R8 permit after reset", beam_permit, 1);
    check("R8 trip_ch after reset", trip_ch, 0);
    rd(2, 5);
    check("R8 record after reset", rd_max, 0);

    for (int e = 0; e < 32; e++)
      for (int c = 0; c < N_CH; c++)
        for (int w = 0; w < N_WIN; w++) begin
          @(negedge clk);
          thr_we = 1; thr_addr = {E_W'(e), CH_W'(c), WIN_W'(w)};
          thr_wdata = THR_W'(thr_of(e, c, w));
        end
    @(negedge clk); thr_we = 0;

    // R2 R1: sweep every slot at exactly its limit, no trip anywhere
    for (int e = 0; e < 32; e++)
      for (int c = 0; c < N_CH; c++)
        for (int w = 0; w < N_WIN; w++) begin
          send(c, w, e, thr_of(e, c, w));
          check("R2 equal does not trip", beam_permit, 1);
        end
    tick();
    // R9: maxima are the energy-31 limits
    for (int c = 0; c < N_CH; c++)
      for (int w = 0; w < N_WIN; w++) begin
        rd(c, w);
        check("R9 record max", rd_max, thr_of(31, c, w));
        check("R9 record thr", rd_thr, thr_of(31, c, w));
      end

    // R6 R3: unmaskable channel 0 trips despite inhibit, one cycle later
    inhibit = 1;
    send(0, 3, 5, thr_of(5, 0, 3) + 1);
    check("R3 permit still high after first edge", early_permit, 1);
    check("R6 unmaskable trips under inhibit", beam_permit, 0);
    check("R10 trip flag ch0", trip_ch, 1);
    repeat (4) @(negedge clk);
    check("R7 trip stays latched", beam_permit, 0);
    pulse_clear();
    @(negedge clk);
    check("R7 clear restores permit", beam_permit, 1);
    check("R7 clear empties trip_ch", trip_ch, 0);

    // R4: unconnected channel 2
    inhibit = 0;
    send(2, 7, 9, thr_of(9, 2, 7) + 1000);
    check("R4 unconnected ignored permit", beam_permit, 1);
    check("R4 unconnected ignored trip_ch", trip_ch, 0);

    // R5: maskable channel 1
    inhibit = 1;
    send(1, 11, 20, thr_of(20, 1, 11) + 1);
    check("R5 inhibited maskable dropped", beam_permit, 1);
    inhibit = 0;
    send(1, 11, 20, thr_of(20, 1, 11) + 1);
    check("R5 maskable trips without inhibit", beam_permit, 0);
    check("R10 trip flag ch1", trip_ch, 2);
    send(3, 0, 0, thr_of(0, 3, 0) + 5);
    check("R10 trip flags ch1 and ch3", trip_ch, 10);
    pulse_clear();
    @(negedge clk);
    check("R7 clear after two trips", beam_permit, 1);

    // R1: energy selects the limit
    send(0, 4, 11, thr_of(10, 0, 4) + 1);
    check("R1 higher energy limit no trip", beam_permit, 1);
    send(0, 4, 9, thr_of(10, 0, 4) + 1);
    check("R1 lower energy limit trips", beam_permit, 0);
    pulse_clear();
    @(negedge clk);
    check("R1 cleared", beam_permit, 1);

    // R9: restart after tick
    tick();
    send(3, 2, 0, 7);
    tick();
    rd(3, 2);
    check("R9 new second max", rd_max, 7);
    check("R9 new second thr", rd_thr, thr_of(0, 3, 2));
    rd(0, 0);
    check("R9 untouched slot cleared", rd_max, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule